// File: doc/BRIEF.md
# Multi-Cycle 32-bit Processor Core with Register Swap and Three-Source Add

This block is a small 32-bit processor that splits each instruction into a short series of clock cycles. One ALU does all the arithmetic. One memory port serves both instruction fetch and data access. A register file with two read ports and one write port holds the architectural state. Internal holding registers keep values from one cycle to the next: the instruction, the two operands read from the register file, the memory data word and the ALU result. A finite-state controller sets the datapath for each cycle.

The core runs register-register arithmetic, word loads and stores, branch-if-equal and absolute jumps. It also runs two added instructions.
- **Swap** exchanges two registers using two write cycles.
- **Three-source add** sums three registers. It reuses the single ALU twice, feeding the first partial sum back into the ALU.

Neither instruction needs another ALU or another register-file port.

The memory is outside the core and answers reads in the same cycle: `mem_rdata` must reflect `mem_addr` combinationally. A write takes effect at the clock edge that ends the cycle in which `mem_wr` is high. Debug outputs show:
- the program counter;
- the controller state;
- every register-file write.

A system can use these outputs to trace execution and count the cycles each instruction takes.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` equals the RESET_PC parameter (default 0) and `dbg_state` is 0 (fetch). `rst_n` is an asynchronous active-low reset.
- R2: State encoding is: 0 fetch, 1 decode, 2 address, 3 mem-read, 4 load-writeback, 5 store, 6 execute, 7 ALU-writeback, 8 branch, 9 jump, 10 swap-first, 11 swap-second, 12 sum-pair, 13 sum-third, 14 sum-writeback. Fetch reads the word at PC and is always followed by decode. By decode, PC has advanced by 4.
- R3: Opcode 0x00 is register-register. Bits [25:21] are the first source, [20:16] the second source, [15:11] the destination and [5:0] the function. Function codes are: 32 add, 34 subtract, 36 and, 37 or, 39 nor, 42 signed set-less-than. This instruction takes 4 cycles.
- R4: Opcode 0x23 (load) and opcode 0x2B (store) use the address R[[25:21]] + sign-extended [15:0]. A load writes R[[20:16]] and takes 5 cycles. A store writes memory from R[[20:16]] and takes 4 cycles.
- R5: Opcode 0x04 compares R[[25:21]] with R[[20:16]] and takes 3 cycles. When they are equal, PC becomes PC+4 + 4×sign-extended [15:0]. Otherwise PC stays at PC+4.
- R6: Opcode 0x02 sets PC to {(PC+4)[31:28], [25:0], 00} and takes 3 cycles.
- R7: Opcode 0x38 (swap) has bits [15:11] equal to bits [25:21]. It exchanges R[[15:11]] and R[[20:16]] in 4 cycles. The first write goes to the register named by [15:11] and the second to the register named by [20:16]. Both writes use the values held before the instruction.
- R8: Opcode 0x39 (three-source add) writes R[[25:21]] + R[[20:16]] + R[[4:0]] into R[[15:11]] and takes 5 cycles.
- R9: Register 0 always reads as zero. A write to it has no effect.
- R10: `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show each register-file write during the cycle it commits. Writes occur only in states 4, 7, 10, 11 and 14.
- R11: Any other opcode returns to fetch right after decode. It takes 2 cycles and changes no register or memory.
- R12: `mem_wr` is high only in the store state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Combinational read data for `mem_addr` |
| dbg_pc | output | 32 | Current program counter |
| dbg_state | output | 4 | Controller state code |
| dbg_wr_en | output | 1 | Register write happening this cycle |
| dbg_wr_addr | output | 5 | Register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The hardest case to reach from the ports is a swap. Its second write must take the pre-instruction value of the first register, after that register has already been overwritten. Only a program that loads distinct values, swaps them and then stores both registers shows a wrong ordering or stale operand at the memory port.

The bench therefore runs one fixed program under several operand triples. These include sign extremes and overflowing sums. The program also covers:
- a self-swap;
- a write to register 0;
- taken and untaken branches;
- an undefined opcode.

Each triple's expected register writes, stores and per-instruction cycle counts are computed arithmetically.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_SWAP  = 6'h38;
  localparam logic [5:0] OP_ADD3  = 6'h39;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_ADDR    = 4'd2,
    S_MREAD   = 4'd3,
    S_LDWB    = 4'd4,
    S_STORE   = 4'd5,
    S_EXEC    = 4'd6,
    S_ALUWB   = 4'd7,
    S_BRANCH  = 4'd8,
    S_JUMP    = 4'd9,
    S_SWAP_1  = 4'd10,
    S_SWAP_2  = 4'd11,
    S_SUM_AB  = 4'd12,
    S_SUM_X   = 4'd13,
    S_SUM_WB  = 4'd14
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT
  } alu_op_t;

  typedef enum logic [1:0] {SA_PC, SA_OPA, SA_ACC} srca_t;
  typedef enum logic [1:0] {SB_OPB, SB_FOUR, SB_IMM, SB_OFS} srcb_t;
  typedef enum logic [1:0] {PS_ALU, PS_ACC, PS_JMP} pcsrc_t;
  typedef enum logic [1:0] {WD_ACC, WD_MDR, WD_OPA, WD_OPB} wdsel_t;

  typedef struct packed {
    logic    use_acc_addr;
    logic    ir_load;
    logic    pc_load;
    logic    pc_load_eq;
    logic    mem_wr;
    logic    rf_wr;
    logic    dst_is_rd;
    logic    rd2_is_rx;
    logic    opb_load;
    srca_t   srca;
    srcb_t   srcb;
    alu_op_t op;
    pcsrc_t  pcsrc;
    wdsel_t  wdsel;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = ($signed(a) < $signed(b)) ? {{(W-1){1'b0}}, 1'b1} : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int N = 1 << AW;

  logic [W-1:0] cells [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cells[i] <= '0;
    end else if (we && (wa != '0)) begin
      cells[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : cells[ra1];
  assign rd2 = (ra2 == '0) ? '0 : cells[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctrl_t      ctl
);
  state_t nxt;

  function automatic alu_op_t fn_to_op(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_NOR:  return ALU_NOR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = S_FETCH;
    unique case (state)
      S_FETCH: begin
        ctl.ir_load = 1'b1;
        ctl.srca    = SA_PC;
        ctl.srcb    = SB_FOUR;
        ctl.pcsrc   = PS_ALU;
        ctl.pc_load = 1'b1;
        nxt         = S_DECODE;
      end
      S_DECODE: begin
        ctl.srca     = SA_PC;
        ctl.srcb     = SB_OFS;
        ctl.opb_load = 1'b1;
        case (opcode)
          OP_RTYPE:          nxt = S_EXEC;
          OP_LOAD, OP_STORE: nxt = S_ADDR;
          OP_BEQ:            nxt = S_BRANCH;
          OP_JUMP:           nxt = S_JUMP;
          OP_SWAP:           nxt = S_SWAP_1;
          OP_ADD3:           nxt = S_SUM_AB;
          default:           nxt = S_FETCH;
        endcase
      end
      S_ADDR: begin
        ctl.srca = SA_OPA;
        ctl.srcb = SB_IMM;
        nxt      = (opcode == OP_LOAD) ? S_MREAD : S_STORE;
      end
      S_MREAD: begin
        ctl.use_acc_addr = 1'b1;
        nxt              = S_LDWB;
      end
      S_LDWB: begin
        ctl.rf_wr = 1'b1;
        ctl.wdsel = WD_MDR;
      end
      S_STORE: begin
        ctl.use_acc_addr = 1'b1;
        ctl.mem_wr       = 1'b1;
      end
      S_EXEC: begin
        ctl.srca = SA_OPA;
        ctl.srcb = SB_OPB;
        ctl.op   = fn_to_op(funct);
        nxt      = S_ALUWB;
      end
      S_ALUWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.dst_is_rd = 1'b1;
        ctl.wdsel     = WD_ACC;
      end
      S_BRANCH: begin
        ctl.srca       = SA_OPA;
        ctl.srcb       = SB_OPB;
        ctl.op         = ALU_SUB;
        ctl.pcsrc      = PS_ACC;
        ctl.pc_load_eq = 1'b1;
      end
      S_JUMP: begin
        ctl.pcsrc   = PS_JMP;
        ctl.pc_load = 1'b1;
      end
      S_SWAP_1: begin
        ctl.rf_wr     = 1'b1;
        ctl.dst_is_rd = 1'b1;
        ctl.wdsel     = WD_OPB;
        nxt           = S_SWAP_2;
      end
      S_SWAP_2: begin
        ctl.rf_wr = 1'b1;
        ctl.wdsel = WD_OPA;
      end
      S_SUM_AB: begin
        ctl.srca      = SA_OPA;
        ctl.srcb      = SB_OPB;
        ctl.rd2_is_rx = 1'b1;
        ctl.opb_load  = 1'b1;
        nxt           = S_SUM_X;
      end
      S_SUM_X: begin
        ctl.srca = SA_ACC;
        ctl.srcb = SB_OPB;
        nxt      = S_SUM_WB;
      end
      S_SUM_WB: begin
        ctl.rf_wr     = 1'b1;
        ctl.dst_is_rd = 1'b1;
        ctl.wdsel     = WD_ACC;
      end
      default: nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic        mem_wr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [31:0] dbg_pc,
  output logic [3:0]  dbg_state,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_addr,
  output logic [31:0] dbg_wr_data
);
  state_t st;
  ctrl_t  ctl;

  logic [XLEN-1:0]   pc_q, ir_q, opa_q, opb_q, mdr_q, acc_q;
  logic [XLEN-1:0]   rd1, rd2, alu_a, alu_b, alu_y, pc_nxt, wr_data, imm_sx;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, f_rx, ra2, wr_addr;
  logic              alu_zero;

  assign f_rs   = ir_q[25:21];
  assign f_rt   = ir_q[20:16];
  assign f_rd   = ir_q[15:11];
  assign f_rx   = ir_q[4:0];
  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign ra2    = ctl.rd2_is_rx ? f_rx : f_rt;

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .state  (st),
    .ctl    (ctl)
  );

  mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (f_rs),
    .ra2   (ra2),
    .we    (ctl.rf_wr),
    .wa    (wr_addr),
    .wd    (wr_data),
    .rd1   (rd1),
    .rd2   (rd2)
  );

  always_comb begin
    unique case (ctl.srca)
      SA_OPA:  alu_a = opa_q;
      SA_ACC:  alu_a = acc_q;
      default: alu_a = pc_q;
    endcase
    unique case (ctl.srcb)
      SB_FOUR: alu_b = 32'd4;
      SB_IMM:  alu_b = imm_sx;
      SB_OFS:  alu_b = {imm_sx[XLEN-3:0], 2'b00};
      default: alu_b = opb_q;
    endcase
    unique case (ctl.pcsrc)
      PS_ACC:  pc_nxt = acc_q;
      PS_JMP:  pc_nxt = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_nxt = alu_y;
    endcase
    unique case (ctl.wdsel)
      WD_MDR:  wr_data = mdr_q;
      WD_OPA:  wr_data = opa_q;
      WD_OPB:  wr_data = opb_q;
      default: wr_data = acc_q;
    endcase
  end

  assign wr_addr = ctl.dst_is_rd ? f_rd : f_rt;

  mc_alu #(.W(XLEN)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .op   (ctl.op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      mdr_q <= '0;
      acc_q <= '0;
    end else begin
      if (ctl.ir_load) ir_q <= mem_rdata;
      opa_q <= rd1;
      if (ctl.opb_load) opb_q <= rd2;
      mdr_q <= mem_rdata;
      acc_q <= alu_y;
      if (ctl.pc_load || (ctl.pc_load_eq && alu_zero)) pc_q <= pc_nxt;
    end
  end

  assign mem_addr    = ctl.use_acc_addr ? acc_q : pc_q;
  assign mem_wr      = ctl.mem_wr;
  assign mem_wdata   = opb_q;
  assign dbg_pc      = pc_q;
  assign dbg_state   = st;
  assign dbg_wr_en   = ctl.rf_wr;
  assign dbg_wr_addr = wr_addr;
  assign dbg_wr_data = wr_data;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  state,
  input logic        mem_wr,
  input logic        wr_en,
  input logic [31:0] pc,
  input logic [31:0] ir
);
  logic known_op;
  assign known_op = (ir[31:26] == 6'h00) || (ir[31:26] == 6'h23) ||
                    (ir[31:26] == 6'h2B) || (ir[31:26] == 6'h04) ||
                    (ir[31:26] == 6'h02) || (ir[31:26] == 6'h38) ||
                    (ir[31:26] == 6'h39);

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |=> state == 4'd1);

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |=> pc == $past(pc) + 32'd4);

  p_store_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> state == 4'd5);

  p_write_states_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == 4'd4 || state == 4'd7 || state == 4'd10 ||
               state == 4'd11 || state == 4'd14));

  p_swap_two_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd10 |=> (state == 4'd11 && wr_en));

  p_sum_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd12 |=> state == 4'd13);

  p_sum_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd14 |=> state == 4'd0);

  p_unknown_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd1 && !known_op) |=> state == 4'd0);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .state  (dbg_state),
  .mem_wr (mem_wr),
  .wr_en  (dbg_wr_en),
  .pc     (dbg_pc),
  .ir     (ir_q)
);

// File: tb/test_mc_core.sv
module test_mc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_pc, dbg_wr_data;
  logic        mem_wr, dbg_wr_en;
  logic [3:0]  dbg_state;
  logic [4:0]  dbg_wr_addr;

  logic [31:0] mem [256];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mc_core i_mc_core (
    .clk (clk), .rst_n (rst_n),
    .mem_addr (mem_addr), .mem_wr (mem_wr), .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata), .dbg_pc (dbg_pc), .dbg_state (dbg_state),
    .dbg_wr_en (dbg_wr_en), .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rt3(input int rs, rt, rd, fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] it3(input logic [5:0] op, input int rs, rt,
                                      input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic string len_tag(input int i);
    if (i <= 2) return "R4";
    if (i <= 8) return "R3";
    if (i == 9) return "R8";
    if (i == 10 || i == 18) return "R7";
    if (i == 13 || i == 14) return "R9";
    if (i == 15 || i == 16) return "R5";
    if (i == 20) return "R11";
    if (i >= 21) return "R6";
    return "R4";
  endfunction

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  task automatic run_case(input logic [31:0] a, b, c);
    logic [31:0] ea [15];
    logic [4:0]  wa [15];
    int exp_len [22] = '{5,5,5,4,4,4,4,4,4,5,4,4,4,4,4,3,3,4,4,4,2,3};
    int widx, idx, len;
    logic [31:0] fpc;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = it3(6'h23, 0, 1, 16'h0200);
    mem[1]  = it3(6'h23, 0, 2, 16'h0204);
    mem[2]  = it3(6'h23, 0, 3, 16'h0208);
    mem[3]  = rt3(1, 2, 4, 32);
    mem[4]  = rt3(1, 2, 5, 34);
    mem[5]  = rt3(1, 2, 6, 36);
    mem[6]  = rt3(1, 2, 7, 37);
    mem[7]  = rt3(1, 2, 8, 39);
    mem[8]  = rt3(1, 2, 9, 42);
    mem[9]  = {6'h39, 5'd1, 5'd2, 5'd10, 6'd0, 5'd3};
    mem[10] = {6'h38, 5'd1, 5'd2, 5'd1, 11'd0};
    mem[11] = it3(6'h2B, 0, 1, 16'h0210);
    mem[12] = it3(6'h2B, 0, 2, 16'h0214);
    mem[13] = rt3(1, 2, 0, 32);
    mem[14] = it3(6'h2B, 0, 0, 16'h0218);
    mem[15] = it3(6'h04, 1, 1, 16'h0001);
    mem[16] = it3(6'h2B, 0, 1, 16'h021C);
    mem[17] = it3(6'h04, 1, 2, 16'h0001);
    mem[18] = it3(6'h2B, 0, 10, 16'h0220);
    mem[19] = {6'h38, 5'd3, 5'd3, 5'd3, 11'd0};
    mem[20] = it3(6'h2B, 0, 3, 16'h0224);
    mem[21] = 32'hFC00_0000;
    mem[22] = {6'h02, 26'd24};
    mem[23] = it3(6'h2B, 0, 1, 16'h0228);
    mem[24] = {6'h02, 26'd24};
    mem[128] = a; mem[129] = b; mem[130] = c;
    mem[135] = SENT; mem[138] = SENT;
    wa = '{5'd1,5'd2,5'd3,5'd4,5'd5,5'd6,5'd7,5'd8,5'd9,5'd10,5'd1,5'd2,5'd0,5'd3,5'd3};
    ea = '{a, b, c, a + b, a - b, a & b, a | b, ~(a | b),
           ($signed(a) < $signed(b)) ? 32'd1 : 32'd0, a + b + c, b, a, a + b, c, c};
    repeat (2) @(negedge clk);
    chk(dbg_pc == 32'h0, "R1 pc", dbg_pc, 32'h0);
    chk(dbg_state == 4'd0, "R1 state", {28'd0, dbg_state}, 32'd0);
    rst_n = 1'b1;
    widx = 0; idx = 0; len = 1; fpc = 32'h0;
    for (int cyc = 0; cyc < 130; cyc++) begin
      @(negedge clk);
      if (dbg_state == 4'd0) begin
        if (idx < 26)
          chk(len == ((idx < 22) ? exp_len[idx] : 3), len_tag(idx), len,
              (idx < 22) ? exp_len[idx] : 3);
        idx++;
        len = 1;
        fpc = dbg_pc;
      end else begin
        len++;
        if (dbg_state == 4'd1) chk(dbg_pc == fpc + 4, "R2 pc step", dbg_pc, fpc + 4);
      end
      if (mem_wr) chk(dbg_state == 4'd5, "R12 write state", {28'd0, dbg_state}, 32'd5);
      if (dbg_wr_en) begin
        if (widx < 15) begin
          chk(dbg_wr_addr == wa[widx], (widx >= 10) ? "R7 waddr" : "R10 waddr",
              {27'd0, dbg_wr_addr}, {27'd0, wa[widx]});
          chk(dbg_wr_data == ea[widx], (widx == 9) ? "R8 sum" : "R3 wdata",
              dbg_wr_data, ea[widx]);
        end else begin
          chk(1'b0, "R10 extra write", {27'd0, dbg_wr_addr}, 32'd0);
        end
        widx++;
      end
    end
    chk(widx == 15, "R10 write count", widx, 15);
    while (dbg_state != 4'd0) @(negedge clk);
    chk(dbg_pc == 32'd96, "R6 jump loop", dbg_pc, 32'd96);
    chk(mem[132] == b, "R7 swapped first", mem[132], b);
    chk(mem[133] == a, "R7 swapped second", mem[133], a);
    chk(mem[134] == 32'h0, "R9 zero reg", mem[134], 32'h0);
    chk(mem[135] == SENT, "R5 branch skip", mem[135], SENT);
    chk(mem[136] == a + b + c, "R8 stored sum", mem[136], a + b + c);
    chk(mem[137] == c, "R7 self swap", mem[137], c);
    chk(mem[138] == SENT, "R6 jump skip", mem[138], SENT);
    chk(mem[139] == 32'h0, "R11 no side effect", mem[139], 32'h0);
  endtask

  initial begin
    run_case(32'd5, 32'd3, 32'd7);
    run_case(32'hFFFF_FFFE, 32'd9, 32'd100);
    run_case(32'h7FFF_FFFF, 32'd1, 32'd1);
    run_case(32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678);
    run_case(32'd0, 32'hAAAA_5555, 32'h5555_AAAA);
    run_case(32'hFFFF_FF9C, 32'hFFFF_FF38, 32'd3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule